// File: doc/BRIEF.md
# Pattern-Triggered Synchronous Serial Receiver

This block receives synchronous serial frames. An external bit clock is brought into the core clock domain as a one-cycle enable strobe. On each strobe the block samples one data bit and the frame-sync line. A frame begins on a selectable start event: a rising or falling edge of frame sync, or a sliding-window match between the most recent N received bits and a compare pattern. After the start event the receiver skips a programmed number of bit periods. It then assembles words of programmed length, MSB-first or LSB-first.

A completed word is held on a valid/ready output. An overrun pulse is raised when a new word replaces one that was never taken. A one-cycle sync pulse marks each detected frame-sync edge. There are two ways to end a frame. It can stop after a set number of words, and in that case the compare start must be re-armed before it can fire again. Or it can run until a second compare pattern is seen on the same sliding window. All configuration arrives on static input ports.

Top module: `pattern_sync_rx`

## Requirements
- R1: After reset, valid_o, overrun_o and sync_o are low, the receiver is idle, and the compare start is disarmed.
- R2: The line start_mode_i selects the start event: 0 is a rising edge of fsync_i, 1 is a falling edge of fsync_i, 2 is a compare-0 match, and 3 never starts a frame. fsync_i is sampled only on bit_en_i cycles, and its sampled value before the first sample is 0.
- R3: In start modes 0 and 1, sync_o pulses high for one cycle, the cycle after a sample at which the selected fsync_i edge is seen. This happens in any receiver state.
- R4: In mode 2, a frame starts at a sample where the last N samples equal the low N bits of cmp0_i, with N = sync_len_i (1..16) and the newest bit in bit 0. A start also needs that at least N samples have arrived since reset, and that the compare is armed. An arm_i pulse arms the compare, and starting a frame disarms it. While disarmed, a matching pattern starts nothing.
- R5: After the start-event sample, delay_i samples (0..255) are skipped. With delay_i = 0, the first data bit is the very next sample.
- R6: Each word is word_len_i+1 bits long (1..32). With msb_first_i = 1, the first bit received lands in bit word_len_i. With msb_first_i = 0, the first bit lands in bit 0. All bits above the word length are 0.
- R7: With stop_mode_i = 0, the receiver returns to idle after word_cnt_i+1 words. Samples that follow produce no word until a new start event.
- R8: With stop_mode_i = 1, words continue past word_cnt_i+1 until the last N samples, taken in the delay or data phase, match the low N bits of cmp1_i. A word that completes on the matching sample is still delivered. A partially assembled word is discarded.
- R9: A completed word appears on word_o with valid_o high from the cycle after its last sample. valid_o stays high until a cycle with ready_i high. With ready_i held high, valid_o is a one-cycle pulse.
- R10: When a word completes while valid_o is high and ready_i is low, overrun_o pulses for one cycle and word_o takes the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | One-cycle strobe per bit-clock rising edge |
| rx_data_i | input | 1 | Serial data, sampled on bit_en_i |
| fsync_i | input | 1 | Frame-sync input, sampled on bit_en_i |
| start_mode_i | input | 2 | Start event select |
| stop_mode_i | input | 1 | 0: stop after word count, 1: stop on compare-1 |
| sync_len_i | input | 5 | Compare window length N, 1..16 |
| cmp0_i | input | 16 | Start compare pattern |
| cmp1_i | input | 16 | Stop compare pattern |
| delay_i | input | 8 | Bit periods between start event and first data bit |
| word_len_i | input | 5 | Word length minus one |
| word_cnt_i | input | 4 | Words per frame minus one |
| msb_first_i | input | 1 | Bit order select |
| arm_i | input | 1 | Arms the compare-0 start |
| ready_i | input | 1 | Consumer accepts word_o |
| word_o | output | 32 | Received word |
| valid_o | output | 1 | word_o holds an untaken word |
| overrun_o | output | 1 | One-cycle pulse: untaken word replaced |
| sync_o | output | 1 | One-cycle pulse: frame-sync edge seen |

## Verification
The hardest case to reach is the stop-on-compare-1 ending. Here a word boundary and the compare-1 match land on the same sample, and the window also spans bits that were sampled while the frame was idle or in the start pattern. The stimulus arms compare 0, sends the start pattern, and follows it with byte words chosen so that no window straddling two of them matches either pattern. The stop pattern itself is then sent as a byte-aligned word. The bench expects that word to be delivered and every later bit to be dropped. The disarmed case uses the same pattern stream sent before arm_i.

// File: rtl/pattern_sync_rx_pkg.sv
package pattern_sync_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_DATA  = 2'd2
  } rx_state_e;

  typedef enum logic [1:0] {
    START_FS_RISE = 2'd0,
    START_FS_FALL = 2'd1,
    START_CMP0    = 2'd2,
    START_NONE    = 2'd3
  } start_mode_e;
endpackage

// File: rtl/srx_history.sv
module srx_history #(
  parameter int HIST_W = 16,
  localparam int LEN_W = $clog2(HIST_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_nx_o,
  output logic [LEN_W-1:0]  fill_nx_o
);
  logic [HIST_W-1:0] hist_q;
  logic [LEN_W-1:0]  fill_q;

  assign hist_nx_o = {hist_q[HIST_W-2:0], bit_i};
  assign fill_nx_o = (fill_q == LEN_W'(HIST_W)) ? fill_q : fill_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (bit_en_i) begin
      hist_q <= hist_nx_o;
      fill_q <= fill_nx_o;
    end
  end

  p_fill_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= LEN_W'(HIST_W));
endmodule

// File: rtl/srx_matcher.sv
module srx_matcher #(
  parameter int HIST_W = 16,
  localparam int LEN_W = $clog2(HIST_W + 1)
) (
  input  logic [HIST_W-1:0] hist_i,
  input  logic [HIST_W-1:0] pattern_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              match_o
);
  logic [HIST_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < HIST_W; i++) mask[i] = (LEN_W'(i) < len_i);
    match_o = (len_i != '0) && (((hist_i ^ pattern_i) & mask) == '0);
  end
endmodule

// File: rtl/srx_deser.sv
module srx_deser #(
  parameter int DATA_W = 32,
  localparam int WL_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              clear_i,
  input  logic              bit_i,
  input  logic              msb_first_i,
  input  logic [WL_W-1:0]   len_m1_i,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] sh_q, base, sh_nx;
  logic [WL_W-1:0]   bcnt_q;

  always_comb begin
    base  = (bcnt_q == '0) ? '0 : sh_q;
    sh_nx = msb_first_i ? {base[DATA_W-2:0], bit_i} : {bit_i, base[DATA_W-1:1]};
    done_o = shift_en_i && (bcnt_q == len_m1_i);
    // LSB-first word sits at the top of the register; align it down
    word_o = msb_first_i ? sh_nx : (sh_nx >> (WL_W'(DATA_W - 1) - len_m1_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bcnt_q <= '0;
    end else if (clear_i) begin
      bcnt_q <= '0;
    end else if (shift_en_i) begin
      sh_q   <= sh_nx;
      bcnt_q <= done_o ? '0 : bcnt_q + 1'b1;
    end
  end

  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |-> bcnt_q <= len_m1_i);
endmodule

// File: rtl/pattern_sync_rx.sv
module pattern_sync_rx
  import pattern_sync_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HIST_W = 16,
  parameter int DLY_W  = 8,
  parameter int CNT_W  = 4,
  localparam int LEN_W = $clog2(HIST_W + 1),
  localparam int WL_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              rx_data_i,
  input  logic              fsync_i,
  input  logic [1:0]        start_mode_i,
  input  logic              stop_mode_i,
  input  logic [LEN_W-1:0]  sync_len_i,
  input  logic [HIST_W-1:0] cmp0_i,
  input  logic [HIST_W-1:0] cmp1_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic [WL_W-1:0]   word_len_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  input  logic              msb_first_i,
  input  logic              arm_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o,
  output logic              overrun_o,
  output logic              sync_o
);
  rx_state_e         state_q;
  logic [DLY_W-1:0]  dcnt_q;
  logic [CNT_W-1:0]  wcnt_q;
  logic              armed_q, fs_q;
  logic [HIST_W-1:0] hist_nx;
  logic [LEN_W-1:0]  fill_nx;
  logic [HIST_W-1:0] pats [2];
  logic [1:0]        match;
  logic              fill_ok, m0, m1, fs_rise, fs_fall, start_ev, fs_edge;
  logic              shift_en, word_done;
  logic [DATA_W-1:0] word_nx;

  srx_history #(.HIST_W(HIST_W)) u_hist (
    .clk_i, .rst_ni, .bit_en_i, .bit_i(rx_data_i),
    .hist_nx_o(hist_nx), .fill_nx_o(fill_nx)
  );

  assign pats[0] = cmp0_i;
  assign pats[1] = cmp1_i;

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    srx_matcher #(.HIST_W(HIST_W)) u_match (
      .hist_i(hist_nx), .pattern_i(pats[g]), .len_i(sync_len_i), .match_o(match[g])
    );
  end

  assign fill_ok = fill_nx >= sync_len_i;
  assign m0      = match[0] && fill_ok;
  assign m1      = match[1] && fill_ok;
  assign fs_rise = fsync_i && !fs_q;
  assign fs_fall = !fsync_i && fs_q;

  always_comb begin
    unique case (start_mode_e'(start_mode_i))
      START_FS_RISE: begin start_ev = fs_rise; fs_edge = fs_rise; end
      START_FS_FALL: begin start_ev = fs_fall; fs_edge = fs_fall; end
      START_CMP0:    begin start_ev = armed_q && m0; fs_edge = 1'b0; end
      default:       begin start_ev = 1'b0; fs_edge = 1'b0; end
    endcase
  end

  assign shift_en = bit_en_i && (state_q == ST_DATA);

  srx_deser #(.DATA_W(DATA_W)) u_deser (
    .clk_i, .rst_ni, .shift_en_i(shift_en), .clear_i(state_q != ST_DATA),
    .bit_i(rx_data_i), .msb_first_i, .len_m1_i(word_len_i),
    .done_o(word_done), .word_o(word_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      wcnt_q  <= '0;
      armed_q <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      if (bit_en_i) begin
        fs_q <= fsync_i;
        unique case (state_q)
          ST_IDLE: if (start_ev) begin
            wcnt_q <= '0;
            if (start_mode_i == START_CMP0) armed_q <= 1'b0;
            if (delay_i == '0) state_q <= ST_DATA;
            else begin
              state_q <= ST_DELAY;
              dcnt_q  <= delay_i;
            end
          end
          ST_DELAY: begin
            if (stop_mode_i && m1) state_q <= ST_IDLE;
            else begin
              dcnt_q <= dcnt_q - 1'b1;
              if (dcnt_q == DLY_W'(1)) state_q <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (stop_mode_i) begin
              if (m1) state_q <= ST_IDLE;
            end else if (word_done) begin
              if (wcnt_q == word_cnt_i) state_q <= ST_IDLE;
              else wcnt_q <= wcnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
      if (arm_i) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o    <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
      sync_o    <= 1'b0;
    end else begin
      sync_o    <= bit_en_i && fs_edge;
      overrun_o <= word_done && valid_o && !ready_i;
      if (word_done) begin
        word_o  <= word_nx;
        valid_o <= 1'b1;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  p_valid_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && (overrun_o || $stable(word_o)));
  p_word_on_sample_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(bit_en_i));
  p_overrun_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(valid_o && !ready_i && bit_en_i));
  p_sync_on_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> $past(bit_en_i) && start_mode_i != START_CMP0);
  p_delay_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DELAY |-> dcnt_q != '0);
  p_state_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'd3);
endmodule

// File: tb/pattern_sync_rx_test.sv
module pattern_sync_rx_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        msbf;
    logic [4:0]  lm1;
    logic [3:0]  cm1;
    logic [7:0]  dly;
    logic [31:0] base;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd7,  4'd2,  8'd0,   32'h0000_00A5},
    '{1'b0, 5'd7,  4'd1,  8'd3,   32'h1234_563C},
    '{1'b1, 5'd31, 4'd0,  8'd255, 32'hDEAD_BEEF},
    '{1'b0, 5'd0,  4'd3,  8'd1,   32'h0000_0001},
    '{1'b1, 5'd4,  4'd15, 8'd2,   32'h0000_0016}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 1'b0, rx = 1'b0, fs = 1'b0;
  logic [1:0] start_mode = 2'd0;
  logic stop_mode = 1'b0;
  logic [4:0] sync_len = 5'd8;
  logic [15:0] cmp0 = 16'h0, cmp1 = 16'h0;
  logic [7:0] delay = 8'd0;
  logic [4:0] word_len = 5'd7;
  logic [3:0] word_cnt = 4'd0;
  logic msbf = 1'b1, arm = 1'b0, ready = 1'b1;
  logic [31:0] word;
  logic valid, overrun, sync;

  int checks = 0, errors = 0;
  logic [31:0] rec [64];
  int nrec = 0, ovr_cnt = 0, sync_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_sync_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .rx_data_i(rx), .fsync_i(fs),
    .start_mode_i(start_mode), .stop_mode_i(stop_mode), .sync_len_i(sync_len),
    .cmp0_i(cmp0), .cmp1_i(cmp1), .delay_i(delay), .word_len_i(word_len),
    .word_cnt_i(word_cnt), .msb_first_i(msbf), .arm_i(arm), .ready_i(ready),
    .word_o(word), .valid_o(valid), .overrun_o(overrun), .sync_o(sync)
  );

  always @(negedge clk) begin
    if (valid && ready && nrec < 64) begin
      rec[nrec] = word;
      nrec++;
    end
    if (overrun) ovr_cnt++;
    if (sync) sync_cnt++;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic f);
    @(negedge clk);
    rx = b; fs = f; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w, input int len, input logic mf);
    for (int i = 0; i < len; i++) send_bit(mf ? w[len-1-i] : w[i], 1'b0);
  endtask

  task automatic pulse_arm();
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  function automatic logic [31:0] vword(input vec_t v, input int i);
    logic [31:0] m;
    m = (v.lm1 == 5'd31) ? 32'hFFFF_FFFF : ((32'd1 << (v.lm1 + 1)) - 1);
    return (v.base ^ (i * 32'h9E37_79B9)) & m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!valid && !overrun && !sync, "R1 reset outputs", {valid, overrun, sync}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!valid && !overrun && !sync, "R1 after release", {valid, overrun, sync}, 0);

    // vector table: rising fsync start, stop after count
    for (int v = 0; v < NV; v++) begin
      start_mode = 2'd0; stop_mode = 1'b0;
      msbf = VEC[v].msbf; word_len = VEC[v].lm1;
      word_cnt = VEC[v].cm1; delay = VEC[v].dly;
      nrec = 0;
      send_bit(1'b0, 1'b1);
      for (int d = 0; d < VEC[v].dly; d++) send_bit(1'b1, 1'b0);
      for (int w = 0; w <= VEC[v].cm1; w++) send_word(vword(VEC[v], w), VEC[v].lm1 + 1, VEC[v].msbf);
      for (int e = 0; e < 2 * VEC[v].lm1 + 5; e++) send_bit(e[0], 1'b0);
      repeat (3) @(negedge clk);
      chk(nrec == VEC[v].cm1 + 1, "R7 word count", nrec, VEC[v].cm1 + 1);
      for (int w = 0; w <= VEC[v].cm1; w++)
        chk(rec[w] == vword(VEC[v], w), "R5 R6 word value", rec[w], vword(VEC[v], w));
    end
    chk(sync_cnt == NV, "R3 rising sync pulses", sync_cnt, NV);
    chk(ovr_cnt == 0, "R9 no overrun with ready", ovr_cnt, 0);

    // falling edge start
    start_mode = 2'd1; msbf = 1'b1; word_len = 5'd3; word_cnt = 4'd0; delay = 8'd0;
    nrec = 0; sync_cnt = 0;
    send_bit(1'b0, 1'b1);
    send_bit(1'b0, 1'b0);
    send_word(32'hB, 4, 1'b1);
    send_bit(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk(nrec == 1 && rec[0] == 32'hB, "R2 falling start", rec[0], 32'hB);
    chk(sync_cnt == 1, "R3 falling sync pulse", sync_cnt, 1);

    // mode 3 never starts
    start_mode = 2'd3; nrec = 0; sync_cnt = 0;
    for (int i = 0; i < 12; i++) send_bit(i[1], i[0]);
    send_bit(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(nrec == 0 && sync_cnt == 0, "R2 mode 3 idle", nrec, 0);

    // compare-0 start, disarmed then armed
    start_mode = 2'd2; stop_mode = 1'b0; sync_len = 5'd8;
    cmp0 = 16'hFFA5; cmp1 = 16'h003C; word_len = 5'd7; word_cnt = 4'd0; msbf = 1'b1;
    nrec = 0;
    send_word(32'hA5, 8, 1'b1);
    send_word(32'h5A, 8, 1'b1);
    repeat (3) @(negedge clk);
    chk(nrec == 0, "R4 disarmed no start", nrec, 0);
    pulse_arm();
    send_word(32'hA5, 8, 1'b1);
    send_word(32'h5A, 8, 1'b1);
    send_word(32'hA5, 8, 1'b1);
    send_word(32'h5A, 8, 1'b1);
    repeat (3) @(negedge clk);
    chk(nrec == 1 && rec[0] == 32'h5A, "R4 armed compare start", rec[0], 32'h5A);

    // stop on compare-1, count ignored
    stop_mode = 1'b1; word_cnt = 4'd0; nrec = 0;
    pulse_arm();
    send_word(32'hA5, 8, 1'b1);
    send_word(32'h11, 8, 1'b1);
    send_word(32'h22, 8, 1'b1);
    send_word(32'h33, 8, 1'b1);
    send_word(32'h3C, 8, 1'b1);
    send_word(32'h77, 8, 1'b1);
    send_word(32'h77, 8, 1'b1);
    repeat (3) @(negedge clk);
    chk(nrec == 4, "R8 words until compare-1", nrec, 4);
    chk(rec[0] == 32'h11 && rec[2] == 32'h33, "R8 word data", rec[2], 32'h33);
    chk(rec[3] == 32'h3C, "R8 word on matching sample", rec[3], 32'h3C);

    // valid hold and overrun
    start_mode = 2'd0; stop_mode = 1'b0; word_len = 5'd3; word_cnt = 4'd1; delay = 8'd0;
    ovr_cnt = 0; ready = 1'b0;
    send_bit(1'b0, 1'b1);
    send_word(32'h3, 4, 1'b1);
    repeat (6) @(negedge clk);
    chk(valid && word == 32'h3, "R9 valid held", word, 32'h3);
    chk(ovr_cnt == 0, "R10 no overrun yet", ovr_cnt, 0);
    send_word(32'h9, 4, 1'b1);
    chk(ovr_cnt == 1, "R10 overrun pulse", ovr_cnt, 1);
    chk(valid && word == 32'h9, "R10 word replaced", word, 32'h9);
    @(negedge clk);
    ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!valid, "R9 taken clears valid", valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule